// File: doc/BRIEF.md
# Branch Next-PC Resolver

This block decides where an 8-bit controller core fetches next after a jump or conditional branch. It receives a decoded branch command together with the current program counter, the encoded length of the instruction, and the operands that the condition depends on: the accumulator, the data pointer, the carry flag, one selected bit, two compare bytes and a loop counter. It returns the next program counter and a taken flag. It also returns the side effects that belong to the branch itself: a new carry after a compare, the decremented counter after a decrement-and-branch, and a request to clear the tested bit after a test-and-clear branch.

All results are registered, so the resolver fits into one pipeline stage. Relative targets count from the instruction that follows the branch. Operand fetch and the write-back of carry, counter or bit stay with the surrounding core.

Top module: `brn_unit`

## Requirements
- R1: While `rst_n` is low, `npc_o` is 0, and `taken_o`, `cy_o`, `cnt_o` and `bclr_o` are all 0.
- R2: Every output shows the result for the inputs sampled at the previous rising clock edge. It holds until the next edge, whatever the inputs do in between.
- R3: Command encodings on `cmd_i` are: 0 none, 1 short jump, 2 jump if carry, 3 jump if no carry, 4 jump if accumulator zero, 5 jump if accumulator nonzero, 6 jump if bit set, 7 jump if bit set and clear it, 8 compare and jump if not equal, 9 decrement and jump if nonzero, 10 jump to accumulator plus data pointer, 11 long jump. Codes 0 and 12 to 15 are never taken. When no branch is taken, `npc_o` = (`pc_i` + `len_i`) mod 2^16 and `taken_o` = 0.
- R4: A relative target is `pc_i` + `len_i` + the sign-extended `rel_i` (-128..+127), mod 2^16. The short jump always takes it.
- R5: Code 2 is taken when `cy_i` = 1, and code 3 is taken when `cy_i` = 0. Both use the relative target.
- R6: Code 4 is taken when `acc_i` is 0, and code 5 is taken when `acc_i` is not 0. Both use the relative target.
- R7: Codes 6 and 7 are taken when `bit_i` = 1. `bclr_o` is 1 only for code 7 with `bit_i` = 1.
- R8: Code 8 is taken when `opa_i` differs from `opb_i`, and sets `cy_o` to 1 exactly when `opa_i` < `opb_i`, both read as unsigned 0..255. For every other code, `cy_o` equals `cy_i`.
- R9: Code 9 outputs `cnt_o` = (`cnt_i` - 1) mod 256 and is taken when that result is not 0. For every other code, `cnt_o` equals `cnt_i`.
- R10: Code 10 loads `npc_o` with the zero-extended `acc_i` + `dptr_i` mod 2^16. Code 11 loads `abs_i`. Both are always taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 4 | Branch command code |
| pc_i | input | 16 | Address of the branch instruction |
| len_i | input | 2 | Instruction length in bytes |
| rel_i | input | 8 | Signed relative offset |
| abs_i | input | 16 | Absolute target for the long jump |
| acc_i | input | 8 | Accumulator value |
| dptr_i | input | 16 | Data pointer value |
| cy_i | input | 1 | Current carry flag |
| bit_i | input | 1 | Value of the selected bit |
| opa_i | input | 8 | First compare operand |
| opb_i | input | 8 | Second compare operand |
| cnt_i | input | 8 | Loop counter before the decrement |
| npc_o | output | 16 | Next program counter |
| taken_o | output | 1 | Branch taken |
| cy_o | output | 1 | Carry after the branch |
| cnt_o | output | 8 | Counter after the branch |
| bclr_o | output | 1 | Request to clear the tested bit |

## Verification
The compare branch sets the carry and makes the branch decision in the same cycle, and both come from one pair of bytes. The bench therefore sweeps every `opa_i`/`opb_i` pair and checks `npc_o`, `taken_o` and `cy_o` together. Equal operands must give no jump and a carry of 0, even when `cy_i` is 1. Decrement-and-branch has the same overlap between the new counter value and the branch decision. Every counter value is swept, and the test checks that a count of 1 falls through while a count of 0 wraps to 255 and jumps.

// File: rtl/brn_pkg.sv
package brn_pkg;

  // branch command codes seen on the command input
  typedef enum logic [3:0] {
    BR_NONE     = 4'd0,
    BR_SHORT    = 4'd1,
    BR_IF_C     = 4'd2,
    BR_IF_NC    = 4'd3,
    BR_IF_Z     = 4'd4,
    BR_IF_NZ    = 4'd5,
    BR_IF_BIT   = 4'd6,
    BR_BIT_CLR  = 4'd7,
    BR_CMP_NE   = 4'd8,
    BR_DEC_NZ   = 4'd9,
    BR_IND      = 4'd10,
    BR_LONG     = 4'd11
  } br_cmd_e;

  // which address the next-PC mux picks when the branch is taken
  typedef enum logic [1:0] {
    TGT_SEQ = 2'd0,
    TGT_REL = 2'd1,
    TGT_IND = 2'd2,
    TGT_ABS = 2'd3
  } tgt_sel_e;

endpackage

// File: rtl/brn_cond.sv
module brn_cond
  import brn_pkg::*;
#(
  parameter int D_W = 8
) (
  input  logic [3:0]     cmd,
  input  logic           cy_in,
  input  logic           bit_in,
  input  logic [D_W-1:0] acc,
  input  logic [D_W-1:0] opa,
  input  logic [D_W-1:0] opb,
  input  logic [D_W-1:0] cnt_in,
  output logic           hit,
  output tgt_sel_e       sel,
  output logic           cy_next,
  output logic [D_W-1:0] cnt_next,
  output logic           clr_req
);

  function automatic logic less_u(input logic [D_W-1:0] a, input logic [D_W-1:0] b);
    return (a < b);
  endfunction

  function automatic logic [D_W-1:0] dec_wrap(input logic [D_W-1:0] v);
    return v - {{(D_W-1){1'b0}}, 1'b1};
  endfunction

  logic acc_zero;
  assign acc_zero = (acc == '0);

  always_comb begin
    hit      = 1'b0;
    sel      = TGT_SEQ;
    cy_next  = cy_in;
    cnt_next = cnt_in;
    clr_req  = 1'b0;
    case (cmd)
      BR_SHORT:   begin hit = 1'b1;      sel = TGT_REL; end
      BR_IF_C:    begin hit = cy_in;     sel = TGT_REL; end
      BR_IF_NC:   begin hit = ~cy_in;    sel = TGT_REL; end
      BR_IF_Z:    begin hit = acc_zero;  sel = TGT_REL; end
      BR_IF_NZ:   begin hit = ~acc_zero; sel = TGT_REL; end
      BR_IF_BIT:  begin hit = bit_in;    sel = TGT_REL; end
      BR_BIT_CLR: begin
        hit     = bit_in;
        sel     = TGT_REL;
        clr_req = bit_in;
      end
      BR_CMP_NE: begin
        hit     = (opa != opb);
        sel     = TGT_REL;
        cy_next = less_u(opa, opb);
      end
      BR_DEC_NZ: begin
        cnt_next = dec_wrap(cnt_in);
        hit      = (cnt_next != '0);
        sel      = TGT_REL;
      end
      BR_IND:     begin hit = 1'b1; sel = TGT_IND; end
      BR_LONG:    begin hit = 1'b1; sel = TGT_ABS; end
      default:    begin hit = 1'b0; sel = TGT_SEQ; end
    endcase
  end

endmodule

// File: rtl/brn_target.sv
module brn_target
  import brn_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int D_W   = 8,
  parameter int LEN_W = 2
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [LEN_W-1:0] len,
  input  logic [D_W-1:0]   rel,
  input  logic [PC_W-1:0]  abs_tgt,
  input  logic [D_W-1:0]   acc,
  input  logic [PC_W-1:0]  dptr,
  input  logic             take,
  input  tgt_sel_e         sel,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  next_pc
);

  localparam int REL_PAD = PC_W - D_W;
  localparam int LEN_PAD = PC_W - LEN_W;

  function automatic logic [PC_W-1:0] add_len(input logic [PC_W-1:0] p, input logic [LEN_W-1:0] l);
    return p + {{LEN_PAD{1'b0}}, l};
  endfunction

  function automatic logic [PC_W-1:0] add_rel(input logic [PC_W-1:0] s, input logic [D_W-1:0] r);
    return s + {{REL_PAD{r[D_W-1]}}, r};
  endfunction

  function automatic logic [PC_W-1:0] add_ind(input logic [D_W-1:0] a, input logic [PC_W-1:0] d);
    return d + {{REL_PAD{1'b0}}, a};
  endfunction

  logic [PC_W-1:0] rel_pc;
  logic [PC_W-1:0] ind_pc;

  assign seq_pc = add_len(pc, len);
  assign rel_pc = add_rel(seq_pc, rel);
  assign ind_pc = add_ind(acc, dptr);

  always_comb begin
    next_pc = seq_pc;
    if (take) begin
      case (sel)
        TGT_REL: next_pc = rel_pc;
        TGT_IND: next_pc = ind_pc;
        TGT_ABS: next_pc = abs_tgt;
        default: next_pc = seq_pc;
      endcase
    end
  end

endmodule

// File: rtl/brn_unit.sv
module brn_unit
  import brn_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int D_W   = 8,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cmd_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [D_W-1:0]   rel_i,
  input  logic [PC_W-1:0]  abs_i,
  input  logic [D_W-1:0]   acc_i,
  input  logic [PC_W-1:0]  dptr_i,
  input  logic             cy_i,
  input  logic             bit_i,
  input  logic [D_W-1:0]   opa_i,
  input  logic [D_W-1:0]   opb_i,
  input  logic [D_W-1:0]   cnt_i,
  output logic [PC_W-1:0]  npc_o,
  output logic             taken_o,
  output logic             cy_o,
  output logic [D_W-1:0]   cnt_o,
  output logic             bclr_o
);

  // internal events brought out for the checks below
  logic            ev_hit;
  tgt_sel_e        ev_sel;
  logic            ev_cy;
  logic [D_W-1:0]  ev_cnt;
  logic            ev_clr;
  logic [PC_W-1:0] ev_seq;
  logic [PC_W-1:0] ev_npc;
  logic            armed_q;

  brn_cond #(.D_W(D_W)) u_cond (
    .cmd      (cmd_i),
    .cy_in    (cy_i),
    .bit_in   (bit_i),
    .acc      (acc_i),
    .opa      (opa_i),
    .opb      (opb_i),
    .cnt_in   (cnt_i),
    .hit      (ev_hit),
    .sel      (ev_sel),
    .cy_next  (ev_cy),
    .cnt_next (ev_cnt),
    .clr_req  (ev_clr)
  );

  brn_target #(.PC_W(PC_W), .D_W(D_W), .LEN_W(LEN_W)) u_tgt (
    .pc      (pc_i),
    .len     (len_i),
    .rel     (rel_i),
    .abs_tgt (abs_i),
    .acc     (acc_i),
    .dptr    (dptr_i),
    .take    (ev_hit),
    .sel     (ev_sel),
    .seq_pc  (ev_seq),
    .next_pc (ev_npc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      npc_o   <= '0;
      taken_o <= 1'b0;
      cy_o    <= 1'b0;
      cnt_o   <= '0;
      bclr_o  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      npc_o   <= ev_npc;
      taken_o <= ev_hit;
      cy_o    <= ev_cy;
      cnt_o   <= ev_cnt;
      bclr_o  <= ev_clr;
      armed_q <= 1'b1;
    end
  end

  AST_FALL_THROUGH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !taken_o) |-> (npc_o == $past(pc_i) + {{(PC_W-LEN_W){1'b0}}, $past(len_i)})); // R3

  AST_CLR_ONLY_ON_JBC: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && bclr_o) |-> ($past(cmd_i) == BR_BIT_CLR && $past(bit_i))); // R7

  AST_CARRY_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(cmd_i) != BR_CMP_NE) |-> (cy_o == $past(cy_i))); // R8

  AST_CMP_EQUAL_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(cmd_i) == BR_CMP_NE && $past(opa_i) == $past(opb_i)) |-> (!taken_o && !cy_o)); // R8

  AST_DEC_ONE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(cmd_i) == BR_DEC_NZ && $past(cnt_i) == {{(D_W-1){1'b0}}, 1'b1}) |-> (!taken_o && cnt_o == '0)); // R9

  AST_LONG_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(cmd_i) == BR_LONG) |-> (taken_o && npc_o == $past(abs_i))); // R10

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (!taken_o && !bclr_o)); // R1

endmodule

// File: tb/tb_brn_unit.sv
module tb_brn_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd_i = '0;
  logic [15:0] pc_i = '0;
  logic [1:0]  len_i = '0;
  logic [7:0]  rel_i = '0;
  logic [15:0] abs_i = '0;
  logic [7:0]  acc_i = '0;
  logic [15:0] dptr_i = '0;
  logic        cy_i = 1'b0;
  logic        bit_i = 1'b0;
  logic [7:0]  opa_i = '0;
  logic [7:0]  opb_i = '0;
  logic [7:0]  cnt_i = '0;
  logic [15:0] npc_o;
  logic        taken_o;
  logic        cy_o;
  logic [7:0]  cnt_o;
  logic        bclr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  brn_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .pc_i(pc_i), .len_i(len_i),
    .rel_i(rel_i), .abs_i(abs_i), .acc_i(acc_i), .dptr_i(dptr_i),
    .cy_i(cy_i), .bit_i(bit_i), .opa_i(opa_i), .opb_i(opb_i), .cnt_i(cnt_i),
    .npc_o(npc_o), .taken_o(taken_o), .cy_o(cy_o), .cnt_o(cnt_o), .bclr_o(bclr_o)
  );

  // drive one vector at a falling edge, let one rising edge pass, compare
  task automatic run_vec(input string tag, input int cmd, input int pc, input int len,
                         input int rel, input int abs, input int acc, input int dptr,
                         input int cy, input int bt, input int a, input int b, input int cnt);
    int seq, off, tgt, tk, e_npc, e_cy, e_cnt, e_clr;
    cmd_i = cmd[3:0]; pc_i = pc[15:0]; len_i = len[1:0]; rel_i = rel[7:0];
    abs_i = abs[15:0]; acc_i = acc[7:0]; dptr_i = dptr[15:0]; cy_i = cy[0];
    bit_i = bt[0]; opa_i = a[7:0]; opb_i = b[7:0]; cnt_i = cnt[7:0];
    @(negedge clk);
    seq   = (pc + len) % 65536;
    off   = (rel > 127) ? rel - 256 : rel;
    tgt   = (seq + off + 65536) % 65536;
    tk    = 0; e_cy = cy; e_cnt = cnt; e_clr = 0;
    case (cmd)
      1: tk = 1;
      2: tk = (cy == 1);
      3: tk = (cy == 0);
      4: tk = (acc == 0);
      5: tk = (acc != 0);
      6: tk = bt;
      7: begin tk = bt; e_clr = bt; end
      8: begin tk = (a != b); e_cy = (a < b); end
      9: begin e_cnt = (cnt + 255) % 256; tk = (e_cnt != 0); end
      10: begin tk = 1; tgt = (acc + dptr) % 65536; end
      11: begin tk = 1; tgt = abs; end
      default: tk = 0;
    endcase
    e_npc = tk ? tgt : seq;
    n_tests++;
    if (int'(npc_o) != e_npc || int'(taken_o) != tk || int'(cy_o) != e_cy ||
        int'(cnt_o) != e_cnt || int'(bclr_o) != e_clr) begin
      n_fail++;
      $display("FAIL %s cmd=%0d: npc/tk/cy/cnt/clr actual %h/%0d/%0d/%0d/%0d expected %h/%0d/%0d/%0d/%0d",
               tag, cmd, npc_o, taken_o, cy_o, cnt_o, bclr_o, e_npc, tk, e_cy, e_cnt, e_clr);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    cmd_i = 4'd11; abs_i = 16'hBEEF; cy_i = 1'b1; bit_i = 1'b1; cnt_i = 8'd9;
    repeat (3) @(negedge clk);
    // R1 reset state
    n_tests++;
    if (npc_o != 16'h0 || taken_o || cy_o || cnt_o != 8'h0 || bclr_o) begin
      n_fail++;
      $display("FAIL R1: actual %h/%0d/%0d/%0d/%0d expected 0000/0/0/0/0",
               npc_o, taken_o, cy_o, cnt_o, bclr_o);
    end
    rst_n = 1'b1;

    // R3 never-taken codes, including wrap of the sequential address
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c >= 12) begin
        run_vec("R3", c, 16'hFFFF, 3, 8'h80, 16'h1234, 0, 16'h4000, 1, 1, 1, 2, 1);
        run_vec("R3", c, 16'h0100, 1, 8'h05, 16'h1234, 7, 16'h4000, 0, 1, 3, 3, 0);
      end
    end

    // R4 short jump, all offsets, near both ends of the address space
    for (int r = 0; r < 256; r++) begin
      run_vec("R4", 1, 16'hFFF0, 2, r, 0, 1, 0, 0, 0, 0, 0, 5);
      run_vec("R4", 1, 16'h0010, 2, r, 0, 1, 0, 1, 0, 0, 0, 5);
    end

    // R5 carry-conditioned branches
    for (int r = 0; r < 256; r += 17) begin
      for (int cv = 0; cv < 2; cv++) begin
        run_vec("R5", 2, 16'h2000 + r, 2, r, 0, 4, 0, cv, 0, 0, 0, 3);
        run_vec("R5", 3, 16'h2000 + r, 2, r, 0, 4, 0, cv, 0, 0, 0, 3);
      end
    end

    // R6 accumulator-zero branches over every accumulator value
    for (int av = 0; av < 256; av++) begin
      run_vec("R6", 4, 16'h3000, 2, 8'hF0, 0, av, 0, av % 2, 0, 0, 0, 0);
      run_vec("R6", 5, 16'h3000, 2, 8'h10, 0, av, 0, av % 2, 0, 0, 0, 0);
    end

    // R7 bit branches and the clear request
    for (int bv = 0; bv < 2; bv++) begin
      run_vec("R7", 6, 16'h4000, 3, 8'h22, 0, 0, 0, 0, bv, 0, 0, 0);
      run_vec("R7", 7, 16'h4000, 3, 8'hDE, 0, 0, 0, 1, bv, 0, 0, 0);
      run_vec("R7", 7, 16'hFFFE, 3, 8'h7F, 0, 0, 0, 0, bv, 0, 0, 0);
    end

    // R8 compare branch: every operand pair, carry in alternating
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        run_vec("R8", 8, 16'h5000, 3, 8'hFD, 0, 0, 0, (a + b) % 2, 0, a, b, 0);
      end
    end
    // R8 carry untouched by a non-compare command whose operands would set it
    run_vec("R8", 4, 16'h5000, 2, 0, 0, 0, 0, 1, 0, 0, 200, 0);
    run_vec("R8", 11, 16'h5000, 3, 0, 16'h0777, 0, 0, 0, 0, 0, 200, 0);

    // R9 decrement branch over every counter value
    for (int cv = 0; cv < 256; cv++) begin
      run_vec("R9", 9, 16'h6000, 2, 8'hFE, 0, 0, 0, 0, 0, 0, 0, cv);
    end
    // R9 counter untouched by other commands
    run_vec("R9", 1, 16'h6000, 2, 8'h02, 0, 0, 0, 0, 0, 0, 0, 1);

    // R10 computed and long jumps
    for (int av = 0; av < 256; av++) begin
      run_vec("R10", 10, 16'h7000, 1, 0, 0, av, 16'hFFC0, 0, 0, 0, 0, 0);
    end
    run_vec("R10", 11, 16'h7000, 3, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0);
    run_vec("R10", 11, 16'hFFFF, 3, 0, 16'h0000, 0, 0, 1, 0, 0, 0, 0);

    // R2 outputs hold between edges although the inputs change
    run_vec("R2", 11, 16'h0200, 3, 0, 16'h1234, 0, 0, 0, 0, 0, 0, 0);
    cmd_i = 4'd0; pc_i = 16'h0000; len_i = 2'd1;
    #2;
    n_tests++;
    if (npc_o != 16'h1234 || !taken_o) begin
      n_fail++;
      $display("FAIL R2: actual %h/%0d expected 1234/1", npc_o, taken_o);
    end
    @(negedge clk);
    n_tests++;
    if (npc_o != 16'h0001 || taken_o) begin
      n_fail++;
      $display("FAIL R2: actual %h/%0d expected 0001/0", npc_o, taken_o);
    end

    finish_run();
  end

endmodule